// File: doc/BRIEF.md
# Pattern Fill Blit Engine

This block paints a rectangle of a display frame buffer from a small repeating tile. Software programs a set of configuration registers (tile source address, destination corner address, rectangle size, operation code, raster-operation code, pixel format and line pitch), then sets a start bit. The engine walks the destination rectangle row by row. For every pixel it takes the matching pixel of an 8 x 8 pattern tile held in memory, combines it with the current destination pixel through a 4-bit raster operation, and writes the result back.

The tile's base is the source address with its low bits cleared, and the low bits select the tile row and column that land on the rectangle's top-left pixel. Tile coordinates wrap modulo 8. Memory is reached through one synchronous request/grant port. Read data comes back one cycle after the grant. The engine skips any read whose data the chosen raster operation cannot affect.

Top module: `pfill_blit`

## Requirements
- R1: After reset the control register reads 0, every other register reads 0, and `mem_req` is low.
- R2: Register selects on `cfg_sel` are: 0 control, 1 source address, 2 destination address, 3 width, 4 height, 5 operation code, 6 raster code, 7 pixel format (bit 0), 8 line pitch. A control write with bit 7 set, both linear-select bits (bits 1:0) zero and operation code 6 starts the engine. Control bit 7 then reads 1 until the last pixel write has been granted, and reads 0 afterwards. Control bits 1:0 read back as written.
- R3: A control write with bit 7 set is ignored when the operation code is not 6 or a linear-select bit is set. Busy stays 0 and no memory request is made.
- R4: While busy, all register writes are ignored. This includes a second start. Readback and the running fill keep the values in force at start.
- R5: Destination pixel (x, y) is at address dst + y * 2 * pitch + x * bpp. bpp is 1 when format bit 0 is 0 (8 bpp) and 2 when it is 1 (16 bpp).
- R6: The tile base is the source address with its low 6 bits cleared (8 bpp) or low 7 bits cleared (16 bpp). The start column is src[2:0] or src[3:1], and the start row is src[5:3] or src[6:4]. Pixel (x, y) reads the tile at row (row0 + y) mod 8 and column (col0 + x) mod 8, at base + (row * 8 + col) * bpp.
- R7: The width and height registers hold count minus one. A fill performs exactly (width + 1) * (height + 1) pixel writes.
- R8: Each result bit i equals raster-code bit number 2 * s[i] + d[i], where s is the tile pixel and d is the destination pixel. Code 0xC copies the tile unchanged.
- R9: The tile is read only when code[3:2] differs from code[1:0]. The destination is read only when code[3] differs from code[2] or code[1] differs from code[0]. At most one read of each kind is made per pixel.
- R10: A request that is not granted is held the next cycle with the same address and direction.
- R11: `mem_wide` equals format bit 0. In 8 bpp mode only the low byte of a pixel is meaningful, and the upper byte of `mem_wdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select for write and readback |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Readback of the selected register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 16-bit pixel access, 0 = 8-bit |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | PIX_W | Write data |
| mem_gnt | input | 1 | Grant for the current request |
| mem_rdata | input | PIX_W | Read data, valid the cycle after a granted read |

## Verification
The bench goes after tile wrap. Fills start at a non-zero tile row and column and run wider and taller than 8, so a walker that failed to return to the start column at each new line, or to wrap the row, would paint a shifted pattern into the compared frame buffer. It covers one-pixel fills, constant codes that need no reads, and codes that need only one operand. A block that fetched regardless would break the exact read count, and one that wrongly skipped a read would produce wrong pixels. A random grant stream checks that stalled requests hold, and rejected starts and writes during a fill are checked through readback and the absence of memory traffic.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_PAT,
        ST_LAT_PAT,
        ST_RD_DST,
        ST_LAT_DST,
        ST_WR
    } pfb_state_e;

    localparam logic [3:0] SEL_CTRL   = 4'd0;
    localparam logic [3:0] SEL_SRC    = 4'd1;
    localparam logic [3:0] SEL_DST    = 4'd2;
    localparam logic [3:0] SEL_WID    = 4'd3;
    localparam logic [3:0] SEL_HGT    = 4'd4;
    localparam logic [3:0] SEL_OP     = 4'd5;
    localparam logic [3:0] SEL_ROP    = 4'd6;
    localparam logic [3:0] SEL_FMT    = 4'd7;
    localparam logic [3:0] SEL_PITCH  = 4'd8;

    localparam logic [3:0] OP_PAT_FILL = 4'd6;
    localparam int         GO_BIT      = 7;

    // tile pixel influences the result
    function automatic logic rop_needs_pat(input logic [3:0] code);
        return code[3:2] != code[1:0];
    endfunction

    // destination pixel influences the result
    function automatic logic rop_needs_dst(input logic [3:0] code);
        return (code[3] != code[2]) || (code[1] != code[0]);
    endfunction

endpackage

// File: rtl/pfb_regs.sv
module pfb_regs
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DIM_W  = 10,
    parameter int STR_W  = 12,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              done,
    output logic              go,
    output logic              busy,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [DIM_W-1:0]  wid,
    output logic [DIM_W-1:0]  hgt,
    output logic [3:0]        rop,
    output logic              wide,
    output logic [STR_W-1:0]  pitch
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [DIM_W-1:0]  wid;
        logic [DIM_W-1:0]  hgt;
        logic [3:0]        op;
        logic [3:0]        rop;
        logic              wide;
        logic [STR_W-1:0]  pitch;
        logic [1:0]        lin;
        logic              busy;
    } rf_t;

    rf_t rf_d, rf_q;
    logic go_d;
    logic unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        rf_d = rf_q;
        go_d = 1'b0;
        if (cfg_we && !rf_q.busy) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    rf_d.lin = cfg_wdata[1:0];
                    if (cfg_wdata[GO_BIT] && rf_q.op == OP_PAT_FILL
                        && cfg_wdata[1:0] == 2'b00) begin
                        rf_d.busy = 1'b1;
                        go_d      = 1'b1;
                    end
                end
                SEL_SRC:   rf_d.src   = cfg_wdata[ADDR_W-1:0];
                SEL_DST:   rf_d.dst   = cfg_wdata[ADDR_W-1:0];
                SEL_WID:   rf_d.wid   = cfg_wdata[DIM_W-1:0];
                SEL_HGT:   rf_d.hgt   = cfg_wdata[DIM_W-1:0];
                SEL_OP:    rf_d.op    = cfg_wdata[3:0];
                SEL_ROP:   rf_d.rop   = cfg_wdata[3:0];
                SEL_FMT:   rf_d.wide  = cfg_wdata[0];
                SEL_PITCH: rf_d.pitch = cfg_wdata[STR_W-1:0];
                default: ;
            endcase
        end
        if (done) begin
            rf_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        case (cfg_sel)
            SEL_CTRL:  cfg_rdata = CFG_W'({rf_q.busy, 5'b0, rf_q.lin});
            SEL_SRC:   cfg_rdata = CFG_W'(rf_q.src);
            SEL_DST:   cfg_rdata = CFG_W'(rf_q.dst);
            SEL_WID:   cfg_rdata = CFG_W'(rf_q.wid);
            SEL_HGT:   cfg_rdata = CFG_W'(rf_q.hgt);
            SEL_OP:    cfg_rdata = CFG_W'(rf_q.op);
            SEL_ROP:   cfg_rdata = CFG_W'(rf_q.rop);
            SEL_FMT:   cfg_rdata = CFG_W'(rf_q.wide);
            SEL_PITCH: cfg_rdata = CFG_W'(rf_q.pitch);
            default:   cfg_rdata = '0;
        endcase
    end

    assign go    = go_d;
    assign busy  = rf_q.busy;
    assign src   = rf_q.src;
    assign dst   = rf_q.dst;
    assign wid   = rf_q.wid;
    assign hgt   = rf_q.hgt;
    assign rop   = rf_q.rop;
    assign wide  = rf_q.wide;
    assign pitch = rf_q.pitch;

    AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy); // R2

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2

    AST_BAD_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && cfg_sel == SEL_CTRL
         && (rf_q.op != OP_PAT_FILL || cfg_wdata[1:0] != 2'b00)) |=> !busy); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable({src, dst, wid, hgt, rop, wide, pitch})); // R4

endmodule

// File: rtl/pfb_walker.sv
module pfb_walker #(
    parameter int ADDR_W = 22,
    parameter int DIM_W  = 10,
    parameter int STR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              step,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [DIM_W-1:0]  wid,
    input  logic [DIM_W-1:0]  hgt,
    input  logic              wide,
    input  logic [STR_W-1:0]  pitch,
    output logic [ADDR_W-1:0] pat_addr,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              last
);

    typedef struct packed {
        logic [DIM_W-1:0]  x;
        logic [DIM_W-1:0]  y;
        logic [2:0]        col;
        logic [2:0]        prow;
        logic [ADDR_W-1:0] row;
    } walk_t;

    walk_t w_d, w_q;

    logic [2:0]        col0;
    logic [2:0]        row0;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] row_step;
    logic [6:0]        pat_off;
    logic [DIM_W:0]    pix_off;
    logic              line_end;

    assign col0     = wide ? src[3:1] : src[2:0];
    assign row0     = wide ? src[6:4] : src[5:3];
    assign base     = wide ? {src[ADDR_W-1:7], 7'b0} : {src[ADDR_W-1:6], 6'b0};
    assign row_step = ADDR_W'({pitch, 1'b0});
    assign line_end = (w_q.x == wid);

    always_comb begin
        w_d = w_q;
        if (go) begin
            w_d.x    = '0;
            w_d.y    = '0;
            w_d.col  = col0;
            w_d.prow = row0;
            w_d.row  = dst;
        end else if (step) begin
            if (line_end) begin
                w_d.x    = '0;
                w_d.y    = w_q.y + 1'b1;
                w_d.col  = col0;
                w_d.prow = w_q.prow + 3'd1;
                w_d.row  = w_q.row + row_step;
            end else begin
                w_d.x   = w_q.x + 1'b1;
                w_d.col = w_q.col + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign pat_off  = wide ? {w_q.prow, w_q.col, 1'b0} : {1'b0, w_q.prow, w_q.col};
    assign pix_off  = wide ? {w_q.x, 1'b0} : {1'b0, w_q.x};
    assign pat_addr = base + ADDR_W'(pat_off);
    assign pix_addr = w_q.row + ADDR_W'(pix_off);
    assign last     = line_end && (w_q.y == hgt);

    AST_COL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !go && line_end) |=> (w_q.x == '0 && w_q.col == col0)); // R6

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !go && line_end) |=> (w_q.prow == $past(w_q.prow) + 3'd1)); // R6

    AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !go && !line_end) |=> (w_q.col == $past(w_q.col) + 3'd1)); // R6

endmodule

// File: rtl/pfb_rop.sv
module pfb_rop #(
    parameter int PIX_W = 16
) (
    input  logic [3:0]       code,
    input  logic [PIX_W-1:0] pat,
    input  logic [PIX_W-1:0] dpx,
    output logic [PIX_W-1:0] res
);

    for (genvar i = 0; i < PIX_W; i++) begin : g_bit
        assign res[i] = code[{pat[i], dpx[i]}];
    end

endmodule

// File: rtl/pfill_blit.sv
module pfill_blit
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DIM_W  = 10,
    parameter int STR_W  = 12,
    parameter int CFG_W  = 32,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_gnt,
    input  logic [PIX_W-1:0]  mem_rdata
);

    localparam int BYTE_W = PIX_W / 2;

    typedef struct packed {
        pfb_state_e       st;
        logic [PIX_W-1:0] pat;
        logic [PIX_W-1:0] dpx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              go, busy, done, step, last;
    logic [ADDR_W-1:0] src, dst, pat_addr, pix_addr;
    logic [DIM_W-1:0]  wid, hgt;
    logic [3:0]        rop;
    logic              wide;
    logic [STR_W-1:0]  pitch;
    logic [PIX_W-1:0]  rd_pix, rop_out;
    logic              need_pat, need_dst;
    pfb_state_e        first_st;

    pfb_regs #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .STR_W(STR_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .done(done),
        .go(go), .busy(busy), .src(src), .dst(dst), .wid(wid), .hgt(hgt),
        .rop(rop), .wide(wide), .pitch(pitch)
    );

    pfb_walker #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .STR_W(STR_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .go(go), .step(step), .src(src),
        .dst(dst), .wid(wid), .hgt(hgt), .wide(wide), .pitch(pitch),
        .pat_addr(pat_addr), .pix_addr(pix_addr), .last(last)
    );

    pfb_rop #(.PIX_W(PIX_W)) u_rop (
        .code(rop), .pat(ctl_q.pat), .dpx(ctl_q.dpx), .res(rop_out)
    );

    assign need_pat = rop_needs_pat(rop);
    assign need_dst = rop_needs_dst(rop);
    assign first_st = need_pat ? ST_RD_PAT : (need_dst ? ST_RD_DST : ST_WR);
    assign rd_pix   = wide ? mem_rdata
                           : {{(PIX_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};

    always_comb begin
        ctl_d = ctl_q;
        step  = 1'b0;
        done  = 1'b0;
        case (ctl_q.st)
            ST_IDLE:    if (go) ctl_d.st = first_st;
            ST_RD_PAT:  if (mem_gnt) ctl_d.st = ST_LAT_PAT;
            ST_LAT_PAT: begin
                ctl_d.pat = rd_pix;
                ctl_d.st  = need_dst ? ST_RD_DST : ST_WR;
            end
            ST_RD_DST:  if (mem_gnt) ctl_d.st = ST_LAT_DST;
            ST_LAT_DST: begin
                ctl_d.dpx = rd_pix;
                ctl_d.st  = ST_WR;
            end
            ST_WR: begin
                if (mem_gnt) begin
                    step = 1'b1;
                    if (last) begin
                        done     = 1'b1;
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.st = first_st;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, pat: '0, dpx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req   = (ctl_q.st == ST_RD_PAT) || (ctl_q.st == ST_RD_DST)
                    || (ctl_q.st == ST_WR);
    assign mem_we    = (ctl_q.st == ST_WR);
    assign mem_wide  = wide;
    assign mem_addr  = (ctl_q.st == ST_RD_PAT) ? pat_addr : pix_addr;
    assign mem_wdata = wide ? rop_out
                            : {{(PIX_W-BYTE_W){1'b0}}, rop_out[BYTE_W-1:0]};

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_NARROW_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_wide) |-> (mem_wdata[PIX_W-1:BYTE_W] == '0)); // R11

    AST_DONE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_req && mem_we && mem_gnt)); // R7

endmodule

// File: tb/test_pfill_blit.sv
module test_pfill_blit;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 22;
    localparam int DIM_W  = 10;
    localparam int STR_W  = 12;
    localparam int CFG_W  = 32;
    localparam int PIX_W  = 16;

    logic              clk;
    logic              rst_n;
    logic              cfg_we;
    logic [3:0]        cfg_sel;
    logic [CFG_W-1:0]  cfg_wdata;
    logic [CFG_W-1:0]  cfg_rdata;
    logic              mem_req, mem_we, mem_wide, mem_gnt;
    logic [ADDR_W-1:0] mem_addr;
    logic [PIX_W-1:0]  mem_wdata;
    logic [PIX_W-1:0]  mem_rdata = '0;

    int n_chk = 0, n_bad = 0;
    int n_wr = 0, n_rd = 0;
    int hold_bad = 0, wide_bad = 0;
    bit cur_wide = 0;
    bit gnt_full = 0;

    logic [7:0] mem   [0:65535];
    logic [7:0] ref_m [0:65535];

    pfill_blit #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .STR_W(STR_W), .CFG_W(CFG_W), .PIX_W(PIX_W)
    ) i_pfill_blit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 7 + (i >> 8) * 13 + 5);
    endfunction

    function automatic logic [15:0] rop_fn(input logic [3:0] code,
                                           input logic [15:0] s, input logic [15:0] d);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = code[{s[i], d[i]}];
        return r;
    endfunction

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // memory model: one cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 65536; i++) mem[i] <= init_byte(i);
        end else if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr[15:0]] <= mem_wdata[7:0];
                if (mem_wide) mem[16'(mem_addr[15:0] + 16'd1)] <= mem_wdata[15:8];
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= {mem[16'(mem_addr[15:0] + 16'd1)], mem[mem_addr[15:0]]};
                n_rd <= n_rd + 1;
            end
        end
    end

    // grant driver and port monitor
    initial begin : gnt_drv
        logic pend;
        logic [ADDR_W-1:0] pa;
        logic pw;
        pend = 1'b0; pa = '0; pw = 1'b0; mem_gnt = 1'b0;
        forever begin
            @(negedge clk);
            if (pend && (!mem_req || mem_addr != pa || mem_we != pw)) hold_bad++;
            if (mem_req && mem_we && mem_wide != cur_wide) wide_bad++;
            mem_gnt = gnt_full ? 1'b1 : (($urandom % 4) != 0);
            pend = mem_req && !mem_gnt;
            pa   = mem_addr;
            pw   = mem_we;
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_cfg(input logic [3:0] sel, output logic [31:0] v);
        @(negedge clk);
        cfg_sel = sel;
        #1 v = cfg_rdata;
    endtask

    task automatic ref_blit(input int src, input int dst, input int w, input int h,
                            input logic [3:0] code, input bit wide, input int pitch);
        int bpp, base, c0, r0, pa, da;
        logic [15:0] s, d, r;
        bpp  = wide ? 2 : 1;
        base = wide ? (src & ~127) : (src & ~63);
        c0   = wide ? ((src >> 1) & 7) : (src & 7);
        r0   = wide ? ((src >> 4) & 7) : ((src >> 3) & 7);
        for (int y = 0; y <= h; y++) begin
            for (int x = 0; x <= w; x++) begin
                pa = base + ((((r0 + y) % 8) * 8) + ((c0 + x) % 8)) * bpp;
                da = dst + y * 2 * pitch + x * bpp;
                s  = wide ? {ref_m[pa+1], ref_m[pa]} : {8'h00, ref_m[pa]};
                d  = wide ? {ref_m[da+1], ref_m[da]} : {8'h00, ref_m[da]};
                r  = rop_fn(code, s, d);
                ref_m[da] = r[7:0];
                if (wide) ref_m[da+1] = r[15:8];
            end
        end
    endtask

    task automatic run_blit(input int src, input int dst, input int w, input int h,
                            input logic [3:0] code, input bit wide, input int pitch,
                            input bit poke);
        logic [31:0] v;
        int wr0, rd0, hb0, wb0, cyc, pix, exp_rd, diff_at;
        cur_wide = wide;
        wr_cfg(4'd1, src);
        wr_cfg(4'd2, dst);
        wr_cfg(4'd3, w);
        wr_cfg(4'd4, h);
        wr_cfg(4'd5, 6);
        wr_cfg(4'd6, {28'd0, code});
        wr_cfg(4'd7, {31'd0, wide});
        wr_cfg(4'd8, pitch);
        ref_blit(src, dst, w, h, code, wide, pitch);
        wr0 = n_wr; rd0 = n_rd; hb0 = hold_bad; wb0 = wide_bad;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 32'h80;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 4'd0;
        #1 v = cfg_rdata;
        chk(v[7] == 1'b1, "R2 busy after start", v, 32'h80);
        if (poke) begin
            wr_cfg(4'd1, 32'h1234);
            wr_cfg(4'd6, {28'd0, ~code});
            wr_cfg(4'd0, 32'h80);
        end
        cyc = 0;
        do begin
            rd_cfg(4'd0, v);
            cyc++;
        end while (v[7] && cyc < 20000);
        pix = (w + 1) * (h + 1);
        chk(v[7] == 1'b0, "R2 busy clears", v, 0);
        chk(n_wr - wr0 == pix, "R7 write count", n_wr - wr0, pix);
        exp_rd = pix * (int'(code[3:2] != code[1:0])
                      + int'(code[3] != code[2] || code[1] != code[0]));
        chk(n_rd - rd0 == exp_rd, "R9 read count", n_rd - rd0, exp_rd);
        diff_at = -1;
        for (int i = 0; i < 65536; i++) begin
            if (diff_at < 0 && mem[i] !== ref_m[i]) diff_at = i;
        end
        if (diff_at < 0)
            chk(1'b1, "R5/R6/R8 image", 0, 0);
        else
            chk(1'b0, "R5/R6/R8 image", mem[diff_at], ref_m[diff_at]);
        chk(hold_bad == hb0, "R10 request held", hold_bad - hb0, 0);
        chk(wide_bad == wb0, "R11 width flag", wide_bad - wb0, 0);
        if (poke) begin
            rd_cfg(4'd1, v);
            chk(v == 32'(src), "R4 src frozen", v, src);
            rd_cfg(4'd6, v);
            chk(v == {28'd0, code}, "R4 rop frozen", v, code);
        end
    endtask

    task automatic bad_start(input logic [3:0] op, input logic [31:0] ctrl);
        logic [31:0] v;
        int wr0, rd0;
        wr_cfg(4'd5, {28'd0, op});
        wr0 = n_wr; rd0 = n_rd;
        wr_cfg(4'd0, ctrl);
        #1 v = cfg_rdata;
        cfg_sel = 4'd0;
        #1 v = cfg_rdata;
        chk(v[7] == 1'b0, "R3 start rejected", v, 0);
        chk(v[1:0] == ctrl[1:0], "R2 linear bits readback", v[1:0], ctrl[1:0]);
        repeat (6) @(negedge clk);
        chk(n_wr == wr0 && n_rd == rd0, "R3 no access", n_wr - wr0 + n_rd - rd0, 0);
        wr_cfg(4'd0, 32'h0);
    endtask

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5eed));
        for (int i = 0; i < 65536; i++) ref_m[i] = init_byte(i);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_cfg(4'd0, v);
        chk(v == 0, "R1 ctrl reset", v, 0);
        rd_cfg(4'd1, v);
        chk(v == 0, "R1 src reset", v, 0);
        rd_cfg(4'd8, v);
        chk(v == 0, "R1 pitch reset", v, 0);
        chk(mem_req == 1'b0, "R1 no request", mem_req, 0);

        // R3 rejected starts
        bad_start(4'd5, 32'h80);
        bad_start(4'd6, 32'h81);
        bad_start(4'd6, 32'h82);

        // directed: 8bpp copy, tile start row 4 col 3, wraps both ways
        run_blit(32'h1023, 32'h4000, 9, 9, 4'hC, 1'b0, 8, 1'b0);
        // 16bpp xor, start row 5 col 6
        run_blit(32'h01DC, 32'h4400, 11, 2, 4'h6, 1'b1, 13, 1'b0);
        // single pixel constant fills, full grant
        gnt_full = 1;
        run_blit(32'h0000, 32'h4800, 0, 0, 4'h0, 1'b0, 1, 1'b0);
        run_blit(32'h0040, 32'h4801, 0, 0, 4'hF, 1'b1, 1, 1'b0);
        gnt_full = 0;
        // destination-only and source-only codes
        run_blit(32'h0200, 32'h4900, 16, 3, 4'hA, 1'b0, 12, 1'b0);
        run_blit(32'h0315, 32'h4A00, 12, 4, 4'h5, 1'b1, 14, 1'b0);
        run_blit(32'h0400, 32'h4B00, 9, 8, 4'h3, 1'b0, 6, 1'b0);
        // R4: writes during a long fill
        run_blit(32'h0555, 32'h4C00, 19, 10, 4'hE, 1'b1, 22, 1'b1);

        // constrained random fills
        for (int t = 0; t < 10; t++) begin
            int w, h, bpp, pitch;
            bit wide;
            logic [3:0] code;
            wide  = 1'($urandom % 2);
            bpp   = wide ? 2 : 1;
            w     = $urandom % 21;
            h     = $urandom % 13;
            code  = 4'($urandom % 16);
            pitch = ((w + 1) * bpp + 1) / 2 + ($urandom % 6);
            run_blit($urandom % 32'h1F80, 32'h4000 + ($urandom % 32'h0F00),
                     w, h, code, wide, pitch, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule